// File: doc/BRIEF.md
# Memory Scheduler Major Mode Controller

This block sets the scheduling mode that applies to a whole memory channel. Each cycle it looks at three things: how full the write queue is, whether starved underfill reads are waiting, and whether any isochronous transaction is pending. From these it keeps one registered mode out of four: read, write, partial and isochronous. The downstream command scheduler gets a set of issue enables, one for each transaction class, and a flag that tells it to prefer writes over reads.

Write mode uses hysteresis. The block enters write mode when occupancy reaches a high threshold and leaves it when occupancy drops to a low threshold. Both thresholds are run-time inputs. The hysteresis state is kept even while a higher-priority mode is active. The mode is also driven as a one-hot vector so that performance counters can count the cycles spent in each mode.

Top module: `major_mode_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after it, the mode is read: `modeOneHot` = 4'b0001.
- R2: If occupancy is greater than or equal to `wrHighThresh`, and neither isochronous nor starved-underfill work is pending, the mode is write (`modeOneHot` = 4'b0010) from the next clock edge on.
- R3: If occupancy lies strictly between the two thresholds, the mode does not change between read and write: write stays write and read stays read.
- R4: When occupancy is at or below `wrLowThresh` and below `wrHighThresh`, and nothing of higher priority is pending, the mode is read from the next edge.
- R5: When `underfillStarved` is high and `isochPending` is low, the next mode is partial (`modeOneHot` = 4'b0100), even if write would otherwise be chosen. In partial mode only `issueUnderfill` is high.
- R6: When `isochPending` is high, the next mode is isochronous (`modeOneHot` = 4'b1000), ahead of every other condition. In isochronous mode only `issueIsoch` is high.
- R7: `modeOneHot` has exactly one bit set in every cycle, with read = bit 0, write = bit 1, partial = bit 2, isochronous = bit 3.
- R8: In read and write mode, `issueRead`, `issueWrite` and `issueUnderfill` are high and `issueIsoch` is low. `writeFirst` is high only in write mode.
- R9: The write hysteresis state keeps being updated during partial and isochronous modes. When those modes end, the block returns to write if the drain was armed and occupancy never fell to the low threshold. If occupancy did fall to the low threshold in the meantime, the block returns to read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrOccupancy | input | OCC_W | Current write queue fill level |
| wrHighThresh | input | OCC_W | Fill level that starts a write drain |
| wrLowThresh | input | OCC_W | Fill level that ends a write drain |
| underfillStarved | input | 1 | Starved underfill reads are waiting |
| isochPending | input | 1 | At least one isochronous transaction is pending |
| modeOneHot | output | 4 | Current mode, one-hot |
| issueRead | output | 1 | Regular reads may issue |
| issueWrite | output | 1 | Writes may issue |
| issueUnderfill | output | 1 | Underfill reads may issue |
| issueIsoch | output | 1 | Isochronous transactions may issue |
| writeFirst | output | 1 | Scheduler should prefer writes over reads |

## Verification
The hardest case to reach is the hysteresis memory that survives an interruption (R9). A write drain has to be armed first. Then a partial or isochronous episode has to cover it while occupancy sits between the thresholds. The sequence is run twice: once with occupancy left above the low threshold, so the block must return to write, and once with occupancy briefly dropped to the low threshold during the isochronous episode, so the block must return to read. The stimulus reaches this by driving occupancy, the starved flag and the isochronous flag together, one vector per clock. Each vector carries its expected outcome.

// File: rtl/mmc_pkg.sv
package mmc_pkg;

  typedef enum logic [1:0] {
    MODE_RD   = 2'd0,
    MODE_WR   = 2'd1,
    MODE_PART = 2'd2,
    MODE_ISO  = 2'd3
  } mode_e;

  localparam int NUM_MODES = 4;

  // Threshold comparison results from the datapath
  typedef struct packed {
    logic reachHigh;
    logic atOrBelowLow;
  } occCmp_t;

  // Mode strobes from the control to the issue decoder
  typedef struct packed {
    logic iso;
    logic part;
    logic wr;
    logic rd;
  } modeStrobe_t;

endpackage

// File: rtl/mmc_occ_cmp.sv
module mmc_occ_cmp
  import mmc_pkg::*;
#(
  parameter int OCC_W = 6
) (
  input  logic [OCC_W-1:0] occupancy,
  input  logic [OCC_W-1:0] highThresh,
  input  logic [OCC_W-1:0] lowThresh,
  output occCmp_t          cmp
);

  always_comb begin
    cmp.reachHigh    = (occupancy >= highThresh);
    cmp.atOrBelowLow = (occupancy <= lowThresh);
  end

endmodule

// File: rtl/mmc_mode_fsm.sv
module mmc_mode_fsm
  import mmc_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  occCmp_t     cmp,
  input  logic        underfillStarved,
  input  logic        isochPending,
  output modeStrobe_t strobe
);

  mode_e modeQ, modeD;
  logic  drainQ, drainD;

  // Hysteresis: arm at high threshold, disarm at low threshold
  always_comb begin
    if (cmp.reachHigh)         drainD = 1'b1;
    else if (cmp.atOrBelowLow) drainD = 1'b0;
    else                       drainD = drainQ;
  end

  // Fixed priority: isochronous, partial, write, read
  always_comb begin
    if (isochPending)          modeD = MODE_ISO;
    else if (underfillStarved) modeD = MODE_PART;
    else if (drainD)           modeD = MODE_WR;
    else                       modeD = MODE_RD;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ  <= MODE_RD;
      drainQ <= 1'b0;
    end else begin
      modeQ  <= modeD;
      drainQ <= drainD;
    end
  end

  always_comb begin
    strobe      = '0;
    strobe.rd   = (modeQ == MODE_RD);
    strobe.wr   = (modeQ == MODE_WR);
    strobe.part = (modeQ == MODE_PART);
    strobe.iso  = (modeQ == MODE_ISO);
  end

endmodule

// File: rtl/mmc_issue_dec.sv
module mmc_issue_dec
  import mmc_pkg::*;
(
  input  modeStrobe_t          strobe,
  output logic [NUM_MODES-1:0] modeOneHot,
  output logic                 issueRead,
  output logic                 issueWrite,
  output logic                 issueUnderfill,
  output logic                 issueIsoch,
  output logic                 writeFirst
);

  logic normalTraffic;

  always_comb begin
    modeOneHot     = {strobe.iso, strobe.part, strobe.wr, strobe.rd};
    normalTraffic  = strobe.rd | strobe.wr;
    issueRead      = normalTraffic;
    issueWrite     = normalTraffic;
    issueUnderfill = normalTraffic | strobe.part;
    issueIsoch     = strobe.iso;
    writeFirst     = strobe.wr;
  end

endmodule

// File: rtl/major_mode_ctrl.sv
module major_mode_ctrl
  import mmc_pkg::*;
#(
  parameter int OCC_W = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [OCC_W-1:0] wrOccupancy,
  input  logic [OCC_W-1:0] wrHighThresh,
  input  logic [OCC_W-1:0] wrLowThresh,
  input  logic             underfillStarved,
  input  logic             isochPending,
  output logic [3:0]       modeOneHot,
  output logic             issueRead,
  output logic             issueWrite,
  output logic             issueUnderfill,
  output logic             issueIsoch,
  output logic             writeFirst
);

  occCmp_t     cmp;
  modeStrobe_t strobe;

  mmc_occ_cmp #(.OCC_W(OCC_W)) u_cmp (
    .occupancy  (wrOccupancy),
    .highThresh (wrHighThresh),
    .lowThresh  (wrLowThresh),
    .cmp        (cmp)
  );

  mmc_mode_fsm u_fsm (
    .clk              (clk),
    .rstN             (rstN),
    .cmp              (cmp),
    .underfillStarved (underfillStarved),
    .isochPending     (isochPending),
    .strobe           (strobe)
  );

  mmc_issue_dec u_dec (
    .strobe         (strobe),
    .modeOneHot     (modeOneHot),
    .issueRead      (issueRead),
    .issueWrite     (issueWrite),
    .issueUnderfill (issueUnderfill),
    .issueIsoch     (issueIsoch),
    .writeFirst     (writeFirst)
  );

endmodule

// File: rtl/mmc_checker.sv
module mmc_checker #(
  parameter int OCC_W = 6
) (
  input logic             clk,
  input logic             rstN,
  input logic [OCC_W-1:0] wrOccupancy,
  input logic [OCC_W-1:0] wrHighThresh,
  input logic [OCC_W-1:0] wrLowThresh,
  input logic             underfillStarved,
  input logic             isochPending,
  input logic [3:0]       modeOneHot,
  input logic             issueRead,
  input logic             issueWrite,
  input logic             issueUnderfill,
  input logic             issueIsoch,
  input logic             writeFirst
);

  AST_ONE_MODE: assert property (@(posedge clk) disable iff (!rstN)
    $countones(modeOneHot) == 1); // R7

  AST_ENTER_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && !isochPending && !underfillStarved && wrOccupancy >= wrHighThresh)
      |=> modeOneHot == 4'b0010); // R2

  AST_LEAVE_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && !isochPending && !underfillStarved &&
     wrOccupancy <= wrLowThresh && wrOccupancy < wrHighThresh)
      |=> modeOneHot == 4'b0001); // R4

  AST_ENTER_PARTIAL: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && underfillStarved && !isochPending) |=> modeOneHot == 4'b0100); // R5

  AST_ENTER_ISOCH: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && isochPending) |=> modeOneHot == 4'b1000); // R6

  AST_PARTIAL_BLOCKS: assert property (@(posedge clk) disable iff (!rstN)
    modeOneHot[2] |-> (issueUnderfill && !issueRead && !issueWrite && !issueIsoch)); // R5

  AST_ISOCH_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    modeOneHot[3] |-> (issueIsoch && !issueRead && !issueWrite && !issueUnderfill)); // R6

  AST_WRITE_PRIO: assert property (@(posedge clk) disable iff (!rstN)
    writeFirst |-> (modeOneHot[1] && issueWrite && issueRead)); // R8

endmodule

bind major_mode_ctrl mmc_checker #(.OCC_W(OCC_W)) u_chk (
  .clk              (clk),
  .rstN             (rstN),
  .wrOccupancy      (wrOccupancy),
  .wrHighThresh     (wrHighThresh),
  .wrLowThresh      (wrLowThresh),
  .underfillStarved (underfillStarved),
  .isochPending     (isochPending),
  .modeOneHot       (modeOneHot),
  .issueRead        (issueRead),
  .issueWrite       (issueWrite),
  .issueUnderfill   (issueUnderfill),
  .issueIsoch       (issueIsoch),
  .writeFirst       (writeFirst)
);

// File: tb/major_mode_ctrl_tb.sv
`timescale 1ns/1ps
module major_mode_ctrl_tb;

  localparam int OCC_W = 6;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic [OCC_W-1:0] wrOccupancy = '0;
  logic [OCC_W-1:0] wrHighThresh = 6'd12;
  logic [OCC_W-1:0] wrLowThresh = 6'd4;
  logic             underfillStarved = 1'b0;
  logic             isochPending = 1'b0;
  logic [3:0]       modeOneHot;
  logic             issueRead, issueWrite, issueUnderfill, issueIsoch, writeFirst;

  always #10 clk = ~clk; // 50 MHz

  major_mode_ctrl #(.OCC_W(OCC_W)) u_dut (
    .clk(clk), .rstN(rstN), .wrOccupancy(wrOccupancy),
    .wrHighThresh(wrHighThresh), .wrLowThresh(wrLowThresh),
    .underfillStarved(underfillStarved), .isochPending(isochPending),
    .modeOneHot(modeOneHot), .issueRead(issueRead), .issueWrite(issueWrite),
    .issueUnderfill(issueUnderfill), .issueIsoch(issueIsoch), .writeFirst(writeFirst)
  );

  typedef struct {
    logic [8:0] expBits; // {mode[3:0], rd, wr, uf, iso, wfirst}
    string      tag;
  } item_t;

  item_t expQ[$];
  int vectors = 0;
  int fails = 0;
  bit done = 0;

  // Expected enables derived from R5, R6, R8
  function automatic logic [8:0] expect_bits(input logic [3:0] m);
    logic [4:0] en;
    case (m)
      4'b0001: en = 5'b11100;
      4'b0010: en = 5'b11101;
      4'b0100: en = 5'b00100;
      default: en = 5'b00010;
    endcase
    return {m, en};
  endfunction

  function automatic logic [8:0] actual_bits();
    return {modeOneHot, issueRead, issueWrite, issueUnderfill, issueIsoch, writeFirst};
  endfunction

  task automatic compare(input logic [8:0] exp, input string tag);
    logic [8:0] act;
    act = actual_bits();
    vectors++;
    if (act !== exp || $countones(act[8:5]) != 1) begin
      fails++;
      $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // Driver: one vector per clock, expectation queued
  task automatic drive(input int occ, input bit starved, input bit iso,
                       input logic [3:0] expMode, input string tag);
    @(negedge clk);
    wrOccupancy      = OCC_W'(occ);
    underfillStarved = starved;
    isochPending     = iso;
    expQ.push_back('{expect_bits(expMode), tag});
  endtask

  // Monitor: checks the result after the edge that consumed the vector
  always @(posedge clk) begin
    #5;
    if (expQ.size() > 0) begin
      item_t it;
      it = expQ.pop_front();
      compare(it.expBits, it.tag);
    end
  end

  initial begin : watchdog
    repeat (2000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    #35;
    compare(expect_bits(4'b0001), "R1 in reset");
    @(negedge clk);
    rstN = 1'b1;
    #1 compare(expect_bits(4'b0001), "R1 after release");

    drive(0,  0, 0, 4'b0001, "R1 idle read");
    drive(11, 0, 0, 4'b0001, "R3 below high stays read");
    drive(12, 0, 0, 4'b0010, "R2 reach high");
    drive(8,  0, 0, 4'b0010, "R3 hysteresis hold");
    drive(5,  0, 0, 4'b0010, "R3 just above low");
    drive(4,  0, 0, 4'b0001, "R4 at low");
    drive(8,  0, 0, 4'b0001, "R3 no reentry");
    drive(20, 0, 0, 4'b0010, "R2 above high");
    drive(20, 1, 0, 4'b0100, "R5 partial over write");
    drive(8,  1, 1, 4'b1000, "R6 isoch over all");
    drive(8,  0, 0, 4'b0010, "R9 drain remembered");
    drive(2,  0, 1, 4'b1000, "R6 isoch low occ");
    drive(8,  0, 0, 4'b0001, "R9 drain cleared");
    drive(0,  1, 0, 4'b0100, "R5 partial alone");
    drive(0,  0, 0, 4'b0001, "R4 back to read");
    drive(63, 0, 1, 4'b1000, "R6 isoch full queue");
    drive(63, 0, 0, 4'b0010, "R2 after isoch");
    drive(0,  0, 0, 4'b0001, "R7 R8 final read");

    wait (expQ.size() == 0);
    @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule